// File: doc/BRIEF.md
# Serial command rate stretcher

The block sits on a fast serial command line that carries fixed 12-bit frames at one bit per fast-clock cycle. Each frame opens with a 0, then a 1 marking the start, followed by ten payload bits (a five-bit command code and five bits of data). Front-end chips on the far side can only sample at half rate. The block finds each frame, buffers its payload, and sends the frame out again with every bit held for two fast cycles. Every output change lines up with a free-running half-rate phase enable.

Two things set the output timing: a fixed minimum pipeline delay and the phase of the half-rate enable. The start bit therefore leaves the block 3 or 4 fast cycles after it arrived, so the latency jitters by exactly one cycle. A stretched frame lasts 24 fast cycles. The front end receives a complete command 12 fast cycles later than it would at full rate. A 1 that arrives while a frame is still going out cannot start a new frame. It is dropped and flagged with an error pulse.

Top module: `cmd_stretcher`

## Requirements
- R1: When `active_o` is low and `cmd_i` is sampled 1 at a clock edge, that bit is the start bit and `active_o` is high after that edge.
- R2: `cmd_o` changes value only at a clock edge where `phase_i` was sampled high.
- R3: If the start bit is sampled at edge t, `cmd_o` rises at edge t+3 when `phase_i` is high there, and otherwise at edge t+4. The latency is always 3 or 4 cycles.
- R4: The ten `cmd_i` bits sampled at edges t+1 to t+10 appear on `cmd_o` in arrival order after the start bit. The start bit and each payload bit are held for exactly two cycles (one half-rate period).
- R5: Outside a frame `cmd_o` is 0. Two cycles after the last payload bit appears, `cmd_o` returns to 0 and `active_o` falls at the same edge.
- R6: A 1 on `cmd_i` sampled while `active_o` is high and all ten payload bits are already captured does not alter the output stream. It raises `err_o` for the single following cycle.
- R7: When `rst_ni` is low, `cmd_o`, `active_o` and `err_o` are 0 and any partial frame is discarded.
- R8: A start bit sampled at the first edge after `active_o` falls is accepted as a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 1 | Fast-rate serial command input |
| phase_i | input | 1 | Half-rate phase enable, high every other cycle |
| cmd_o | output | 1 | Stretched serial command output |
| active_o | output | 1 | High while a frame is being received or sent |
| err_o | output | 1 | One-cycle pulse for an ignored start bit |

## Verification
A bad delay count or a wrong alignment state appears at the first output edge of a frame. The start bit then rises outside the 3-to-4 cycle window, or at an edge where the phase was low. A payload buffer written to the wrong slot, or read from the wrong slot, corrupts `cmd_o` within one half-rate period of that bit. A frame-active flag that clears late shows within one cycle. It either suppresses an accepted back-to-back start or adds a spurious error pulse. Comparing every output on every cycle against an independent model therefore localises each fault to the cycle where it first appears.

// File: rtl/cmd_stretch_pkg.sv
package cmd_stretch_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_WAIT = 2'd1,
    TX_SEND = 2'd2
  } tx_state_e;
endpackage

// File: rtl/cmd_capture.sv
module cmd_capture #(
  parameter int PAY_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_i,
  input  logic             done_i,
  output logic             start_o,
  output logic             active_o,
  output logic             err_o,
  output logic [PAY_W-1:0] payload_o
);
  localparam int CW = $clog2(PAY_W + 1);

  logic             active_q;
  logic             err_q;
  logic [CW-1:0]    rx_cnt_q;
  logic [PAY_W-1:0] buf_q;
  logic             rx_busy;

  assign start_o = !active_q && cmd_i;
  assign rx_busy = active_q && (rx_cnt_q < CW'(PAY_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      err_q    <= 1'b0;
      rx_cnt_q <= '0;
      buf_q    <= '0;
    end else begin
      // a 1 after capture completes is a stray start bit
      err_q <= active_q && !rx_busy && cmd_i;
      if (start_o) begin
        active_q <= 1'b1;
        rx_cnt_q <= '0;
      end else begin
        if (done_i) active_q <= 1'b0;
        if (rx_busy) begin
          for (int i = 0; i < PAY_W; i++)
            if (rx_cnt_q == CW'(i)) buf_q[i] <= cmd_i;
          rx_cnt_q <= rx_cnt_q + 1'b1;
        end
      end
    end
  end

  assign active_o  = active_q;
  assign err_o     = err_q;
  assign payload_o = buf_q;
endmodule

// File: rtl/stretch_tx.sv
module stretch_tx
  import cmd_stretch_pkg::*;
#(
  parameter int PAY_W   = 10,
  parameter int MIN_DLY = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             phase_i,
  input  logic [PAY_W-1:0] payload_i,
  output logic             cmd_o,
  output logic             done_o
);
  localparam int DW = $clog2(MIN_DLY + 1);
  localparam int BW = $clog2(PAY_W + 1);

  tx_state_e     state_q;
  logic [DW-1:0] dly_q;
  logic [BW-1:0] idx_q;
  logic          out_q;
  logic          align_ok;
  logic          cur_bit;
  logic          last_slot;

  assign align_ok  = (dly_q >= DW'(MIN_DLY - 1)) && phase_i;
  assign last_slot = (idx_q == BW'(PAY_W));
  assign done_o    = (state_q == TX_SEND) && phase_i && last_slot;

  always_comb begin
    cur_bit = 1'b0;
    for (int i = 0; i < PAY_W; i++)
      if (idx_q == BW'(i)) cur_bit = payload_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      dly_q   <= '0;
      idx_q   <= '0;
      out_q   <= 1'b0;
    end else begin
      unique case (state_q)
        TX_IDLE: begin
          if (start_i) begin
            state_q <= TX_WAIT;
            dly_q   <= '0;
          end
        end
        TX_WAIT: begin
          if (align_ok) begin
            out_q   <= 1'b1;     // start bit
            idx_q   <= '0;
            state_q <= TX_SEND;
          end else if (dly_q < DW'(MIN_DLY - 1)) begin
            dly_q <= dly_q + 1'b1;
          end
        end
        TX_SEND: begin
          if (phase_i) begin
            if (last_slot) begin
              out_q   <= 1'b0;
              state_q <= TX_IDLE;
            end else begin
              out_q <= cur_bit;
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assign cmd_o = out_q;
endmodule

// File: rtl/cmd_stretcher.sv
module cmd_stretcher #(
  parameter int FRAME_W = 12,
  parameter int MIN_DLY = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_i,
  input  logic phase_i,
  output logic cmd_o,
  output logic active_o,
  output logic err_o
);
  localparam int PAY_W = FRAME_W - 2;

  logic             start;
  logic             done;
  logic [PAY_W-1:0] payload;

  cmd_capture #(.PAY_W(PAY_W)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd_i),
    .done_i    (done),
    .start_o   (start),
    .active_o  (active_o),
    .err_o     (err_o),
    .payload_o (payload)
  );

  stretch_tx #(.PAY_W(PAY_W), .MIN_DLY(MIN_DLY)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .phase_i   (phase_i),
    .payload_i (payload),
    .cmd_o     (cmd_o),
    .done_o    (done)
  );
endmodule

// File: rtl/cmd_stretch_chk.sv
module cmd_stretch_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_i,
  input logic phase_i,
  input logic cmd_o,
  input logic active_o,
  input logic err_o
);
  a_r1_start_from_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(cmd_i));

  a_r2_change_on_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cmd_o) |-> $past(phase_i));

  a_r3_rise_inside_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cmd_o) |-> active_o && $past(active_o));

  a_r5_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |-> !cmd_o);

  a_r6_err_needs_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(active_o) && $past(cmd_i));
endmodule

bind cmd_stretcher cmd_stretch_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cmd_i    (cmd_i),
  .phase_i  (phase_i),
  .cmd_o    (cmd_o),
  .active_o (active_o),
  .err_o    (err_o)
);

// File: tb/sim_cmd_stretcher.sv
module sim_cmd_stretcher;
  localparam int PAY_W   = 10;
  localparam int MIN_DLY = 3;

  logic clk = 1'b0, rst_ni = 1'b0, cmd_i = 1'b0, phase_i = 1'b0;
  logic cmd_o, active_o, err_o;

  cmd_stretcher u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd_i), .phase_i(phase_i),
    .cmd_o(cmd_o), .active_o(active_o), .err_o(err_o)
  );

  always #4 clk = ~clk;
  always @(negedge clk) phase_i <= ~phase_i;

  int    n_checks = 0, n_errs = 0;
  int    m_now = 0, m_s = 0, m_j = 0, k = 0;
  int    lat3 = 0, lat4 = 0, err_seen = 0;
  bit    m_active = 0, m_e_ok = 0, exp_out = 0, exp_err = 0;
  bit    prev_out = 0, ph_edge = 0;
  bit    m_pay[$];
  string tag = "R7";

  task automatic check(input bit ok, input string r, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", r, act, exp, $time);
    end
  endtask

  // behavioural reference model, evaluated at every rising edge
  always @(posedge clk) begin
    m_now++;
    ph_edge = phase_i;
    if (!rst_ni) begin
      m_active = 0; m_e_ok = 0; exp_out = 0; exp_err = 0; tag = "R7";
    end else begin
      k = m_now - m_s;
      exp_err = m_active && (k > PAY_W) && cmd_i;
      if (!m_active) begin
        tag = "R5";
        if (cmd_i) begin
          m_active = 1; m_s = m_now; m_e_ok = 0; m_pay.delete(); tag = "R1";
        end
      end else begin
        if (k >= 1 && k <= PAY_W) m_pay.push_back(cmd_i);
        if (!m_e_ok) begin
          if (k >= MIN_DLY && phase_i) begin
            m_e_ok = 1; m_j = 0; exp_out = 1; tag = "R3";
            if (k == 3) lat3++;
            else if (k == 4) lat4++;
            else check(0, "R3 latency", k, 4);
          end
        end else if (phase_i) begin
          tag = "R4";
          if (m_j < PAY_W) exp_out = m_pay[m_j];
          else begin exp_out = 0; m_active = 0; tag = "R5"; end
          m_j++;
        end
      end
    end
    #2;
    check(cmd_o === exp_out, {tag, " cmd_o"}, cmd_o, exp_out);
    check(active_o === m_active, "R1 active_o", active_o, m_active);
    check(err_o === exp_err, "R6 err_o", err_o, exp_err);
    if (cmd_o !== prev_out) check(ph_edge, "R2 change off phase", cmd_o, prev_out);
    if (exp_err && err_o) err_seen++;
    prev_out = cmd_o;
  end

  task automatic send(input bit [PAY_W-1:0] p, input bit now, input bit b2b);
    if (!now) @(negedge clk);
    cmd_i = 1'b1;
    if (b2b) begin
      @(posedge clk); #3;
      check(active_o === 1'b1, "R8 back-to-back start", active_o, 1);
    end
    for (int i = 0; i < PAY_W; i++) begin
      @(negedge clk) cmd_i = p[i];
    end
    @(negedge clk) cmd_i = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (active_o) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(cmd_o === 0 && active_o === 0 && err_o === 0, "R7 reset state",
          {cmd_o, active_o, err_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    send(10'h2A5, 0, 0); wait_idle();
    send(10'h3FF, 0, 0); wait_idle();
    repeat (2) @(negedge clk);
    send(10'h001, 0, 0); wait_idle();
    // stray start bit while stretched frame still going out
    send(10'h155, 0, 0);
    repeat (3) @(negedge clk);
    cmd_i = 1'b1;
    @(negedge clk) cmd_i = 1'b0;
    wait_idle();
    // back-to-back frames
    send(10'h0F3, 1, 1); wait_idle();
    send(10'h30C, 1, 1); wait_idle();
    for (int i = 0; i < 16; i++) begin
      repeat (i % 3) @(negedge clk);
      send(PAY_W'(i * 37 + 5), 0, 0);
      if (i % 4 == 1) begin
        @(negedge clk) cmd_i = 1'b1;
        @(negedge clk) cmd_i = 1'b0;
      end
      wait_idle();
    end
    // reset in mid-frame
    @(negedge clk) cmd_i = 1'b1;
    repeat (4) @(negedge clk) cmd_i = ~cmd_i;
    rst_ni = 1'b0; cmd_i = 1'b0;
    #1;
    check(cmd_o === 0 && active_o === 0 && err_o === 0, "R7 mid-frame reset",
          {cmd_o, active_o, err_o}, 0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    send(10'h2C7, 0, 0); wait_idle();
    repeat (4) @(negedge clk);
    check(lat3 > 0, "R3 latency 3 seen", lat3, 1);
    check(lat4 > 0, "R3 latency 4 seen", lat4, 1);
    check(err_seen > 0, "R6 error pulses seen", err_seen, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_errs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule